// File: doc/BRIEF.md
# Coarse/Fine Edge-Time Scheduler

This block schedules each transition of a square wave whose half-period is finer than one reference-clock cycle. The half-period is given as an unsigned count of 10 ps units. One coarse reference cycle is 10 ns, or 1000 units. A phase accumulator runs from reset and adds one half-period per edge. For each edge the block emits a 16-bit word. The upper field is the number of whole reference cycles since the previous edge, and it feeds a counter. The lower field is the accumulated time modulo one coarse cycle, and it feeds an external delay line with 10 ps steps.

The fine residue is never cleared. Over many edges the average period is therefore exact, even though each single edge is quantised. When the residue crosses one coarse cycle, that edge's divisor is one higher than the base value of the half-period. The intended range is a 950 kHz to 1.05 MHz output in 1 kHz steps, which means half-periods of about 47620 to 52630 units. Any half-period whose divisor stays below 64 is accepted.

A single-cycle load strobe marks each new word. The next word is computed only once the downstream hardware signals through the ready input that the previous edge has been set up.

Top module: `edge_sched`

## Requirements
- R1: While rst_ni is low, load_o is 0 and word_o is 0. The accumulated time is cleared to 0.
- R2: At the first rising clock edge with rst_ni high, the block issues the first word, and load_o is 1 after that edge.
- R3: load_o is never high for two consecutive cycles. A ready_i that is high in a cycle where load_o is high is ignored.
- R4: After the first word, a new word is issued only at a rising edge where ready_i is sampled high and load_o is low. load_o goes high right after that edge.
- R5: word_o[15:10] carries the coarse divisor and word_o[9:0] carries the fine code. The fine code is always within 0 to 999.
- R6: Let T_k be the sum of the half-periods sampled at issues 1 through k. The fine code of word k is T_k mod 1000.
- R7: The divisor of word k is floor(T_k/1000) - floor(T_(k-1)/1000), with T_0 = 0.
- R8: half_period_i is sampled only at an issuing edge. Changes between issues do not alter word_o and do not reset the accumulated time.
- R9: word_o holds its value in every cycle in which load_o is low.
- R10: When the fine residue plus the half-period remainder reaches 1000 or more, the divisor is floor(half_period/1000) + 1. Otherwise it is floor(half_period/1000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_period_i | input | 16 | Wanted half-period in 10 ps units |
| ready_i | input | 1 | Previous edge has been set up; request the next word |
| word_o | output | 16 | {coarse divisor[5:0], fine code[9:0]} |
| load_o | output | 1 | One-cycle strobe marking a new word |

## Verification
The residue rollover (R10) can land on the same issuing edge as a new half-period setting (R8). The bench provokes this by changing half_period_i and raising ready_i in the same cycle, at a point where the old residue plus the new remainder crosses 1000. The word is judged against a cumulative-time model: the divisor must equal the new base plus one, and the fine code must carry the old residue forward. A second overlap is a ready_i held high through a load cycle. Here the strobe must alternate on and off, with no word skipped.

// File: rtl/edge_sched_pkg.sv
package edge_sched_pkg;
  typedef enum logic [0:0] {
    ST_START = 1'b0,
    ST_WAIT  = 1'b1
  } sched_state_e;
endpackage

// File: rtl/edge_sched_split.sv
// Splits a half-period into whole coarse cycles and a sub-cycle remainder.
module edge_sched_split #(
  parameter int HP_W   = 16,
  parameter int DIV_W  = 6,
  parameter int FINE_W = 10,
  parameter int UNITS  = 1000
) (
  input  logic [HP_W-1:0]   hp_i,
  output logic [DIV_W-1:0]  base_o,
  output logic [FINE_W-1:0] rem_o
);
  localparam logic [HP_W-1:0] UnitsHp = HP_W'(UNITS);

  always_comb begin
    base_o = DIV_W'(hp_i / UnitsHp);
    rem_o  = FINE_W'(hp_i % UnitsHp);
  end
endmodule

// File: rtl/edge_sched_acc.sv
// Sub-cycle phase residue; a carry out bumps the divisor of that edge.
module edge_sched_acc #(
  parameter int DIV_W  = 6,
  parameter int FINE_W = 10,
  parameter int UNITS  = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [DIV_W-1:0]  base_i,
  input  logic [FINE_W-1:0] rem_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [FINE_W-1:0] fine_o
);
  localparam int SUM_W = FINE_W + 1;
  localparam logic [SUM_W-1:0] UnitsSum = SUM_W'(UNITS);

  logic [FINE_W-1:0] frac_q;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  sum_red;
  logic              wrap;

  always_comb begin
    sum     = {1'b0, frac_q} + {1'b0, rem_i};
    wrap    = (sum >= UnitsSum);
    sum_red = wrap ? (sum - UnitsSum) : sum;
    fine_o  = sum_red[FINE_W-1:0];
    div_o   = base_i + DIV_W'(wrap);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frac_q <= '0;
    else if (step_i) frac_q <= fine_o;
  end
endmodule

// File: rtl/edge_sched_ctrl.sv
// Issue sequencing: first word after reset, then one per accepted ready.
module edge_sched_ctrl
  import edge_sched_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  output logic step_o,
  output logic load_o
);
  sched_state_e state_q;
  logic         load_q;

  // ready seen during the strobe cycle belongs to the old edge
  assign step_o = (state_q == ST_START) || (ready_i && !load_q);
  assign load_o = load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_START;
      load_q  <= 1'b0;
    end else begin
      load_q <= step_o;
      if (step_o) state_q <= ST_WAIT;
    end
  end
endmodule

// File: rtl/edge_sched.sv
module edge_sched #(
  parameter int HP_W         = 16,
  parameter int DIV_W        = 6,
  parameter int FINE_W       = 10,
  parameter int COARSE_UNITS = 1000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [HP_W-1:0]         half_period_i,
  input  logic                    ready_i,
  output logic [DIV_W+FINE_W-1:0] word_o,
  output logic                    load_o
);
  localparam int WORD_W = DIV_W + FINE_W;

  logic [DIV_W-1:0]  base;
  logic [FINE_W-1:0] rem;
  logic [DIV_W-1:0]  div_nxt;
  logic [FINE_W-1:0] fine_nxt;
  logic              step;
  logic [WORD_W-1:0] word_q;

  edge_sched_split #(
    .HP_W(HP_W), .DIV_W(DIV_W), .FINE_W(FINE_W), .UNITS(COARSE_UNITS)
  ) u_split (
    .hp_i(half_period_i), .base_o(base), .rem_o(rem)
  );

  edge_sched_acc #(
    .DIV_W(DIV_W), .FINE_W(FINE_W), .UNITS(COARSE_UNITS)
  ) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step),
    .base_i(base), .rem_i(rem), .div_o(div_nxt), .fine_o(fine_nxt)
  );

  edge_sched_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(ready_i),
    .step_o(step), .load_o(load_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (step) word_q <= {div_nxt, fine_nxt};
  end

  assign word_o = word_q;
endmodule

// File: rtl/edge_sched_chk.sv
module edge_sched_chk #(
  parameter int DIV_W        = 6,
  parameter int FINE_W       = 10,
  parameter int COARSE_UNITS = 1000
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    ready_i,
  input logic [DIV_W+FINE_W-1:0] word_o,
  input logic                    load_o
);
  logic seen_first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_first_q <= 1'b0;
    else if (load_o) seen_first_q <= 1'b1;
  end

  p_single_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  p_load_needs_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_first_q && load_o) |-> $past(ready_i));

  p_fine_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_o[FINE_W-1:0] < FINE_W'(COARSE_UNITS));

  p_word_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |-> $stable(word_o));

  always_comb begin
    if (!rst_ni) begin
      a_reset_idle_r1: assert (!load_o && word_o == '0);
    end
  end
endmodule

bind edge_sched edge_sched_chk #(
  .DIV_W(DIV_W), .FINE_W(FINE_W), .COARSE_UNITS(COARSE_UNITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_i(ready_i),
  .word_o(word_o), .load_o(load_o)
);

// File: tb/edge_sched_tb.sv
module edge_sched_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] half_period_i = 16'd50000;
  logic        ready_i = 1'b0;
  logic [15:0] word_o;
  logic        load_o;

  int total = 0;
  int bad = 0;
  longint t_acc = 0;

  always #4 clk_i = ~clk_i;

  edge_sched u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .half_period_i(half_period_i),
    .ready_i(ready_i), .word_o(word_o), .load_o(load_o)
  );

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model one issue with half-period hp and compare the word on the ports
  task automatic expect_word(string req, longint hp);
    longint prev = t_acc;
    t_acc = t_acc + hp;
    chk({req, " R7 div"}, longint'(word_o[15:10]), t_acc / 1000 - prev / 1000);
    chk({req, " R6 fine"}, longint'(word_o[9:0]), t_acc % 1000);
    chk({req, " R5 range"}, longint'(word_o[9:0] < 10'd1000), 1);
  endtask

  // one ready pulse with hp; returns at negedge after the issuing edge
  task automatic issue(string req, logic [15:0] hp);
    @(negedge clk_i);
    half_period_i = hp;
    ready_i = 1'b1;
    @(negedge clk_i);
    ready_i = 1'b0;
    chk({req, " R4 load"}, longint'(load_o), 1);
    expect_word(req, longint'(hp));
    @(negedge clk_i);
    chk({req, " R3 drop"}, longint'(load_o), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk("R1 load", longint'(load_o), 0);
    chk("R1 word", longint'(word_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2 first load", longint'(load_o), 1);
    expect_word("R2 first", 50000);
    @(negedge clk_i);
    chk("R3 first drop", longint'(load_o), 0);
  endtask

  task automatic t_wait_ready();
    logic [15:0] held = word_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      chk("R4 no ready no load", longint'(load_o), 0);
      chk("R9 hold", longint'(word_o), longint'(held));
    end
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 8; i++) issue("R10 sweep lo", 16'd47620);
    for (int i = 0; i < 8; i++) issue("R10 sweep hi", 16'd52630);
    for (int i = 0; i < 4; i++) issue("R7 exact", 16'd50000);
    for (int i = 0; i < 6; i++) issue("R6 odd", 16'd49999);
  endtask

  task automatic t_change_between();
    logic [15:0] held = word_o;
    @(negedge clk_i);
    half_period_i = 16'd61000;
    repeat (3) @(negedge clk_i);
    chk("R8 no load on change", longint'(load_o), 0);
    chk("R8 word unchanged", longint'(word_o), longint'(held));
    half_period_i = 16'd48100;
    @(negedge clk_i);
    issue("R8 sampled at issue", 16'd48100);
  endtask

  task automatic t_ready_held();
    @(negedge clk_i);
    half_period_i = 16'd51234;
    ready_i = 1'b1;
    @(negedge clk_i);
    chk("R4 held issue a", longint'(load_o), 1);
    expect_word("R4 held a", 51234);
    @(negedge clk_i);
    chk("R3 ready ignored in strobe", longint'(load_o), 0);
    @(negedge clk_i);
    chk("R4 held issue b", longint'(load_o), 1);
    expect_word("R4 held b", 51234);
    @(negedge clk_i);
    chk("R3 held drop b", longint'(load_o), 0);
    ready_i = 1'b0;
    @(negedge clk_i);
    chk("R4 stop after release", longint'(load_o), 0);
  endtask

  task automatic t_coincide();
    // drive residue to 900, then new setting whose remainder wraps it
    longint need = (1900 - (t_acc % 1000)) % 1000;
    logic [15:0] hp_fix = 16'(48000 + need);
    logic [15:0] hp_new = 16'd52300;
    issue("R10 prep", hp_fix);
    chk("R10 prep residue", longint'(word_o[9:0]), 900);
    issue("R10 wrap with new setting", hp_new);
    chk("R10 div base+1", longint'(word_o[15:10]), 53);
    chk("R10 fine carried", longint'(word_o[9:0]), 200);
  endtask

  initial begin
    t_reset();
    t_wait_ready();
    t_sweep();
    t_change_between();
    t_ready_held();
    t_coincide();
    repeat (2) @(negedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule